// File: doc/BRIEF.md
# Banked Interrupt Status Aggregator

This block gathers twenty-four event inputs into three eight-bit status banks and drives one level-sensitive interrupt line towards a host processor. Every bank has two mask bytes. The capture mask decides whether an event edge is recorded at all. The line mask decides whether a recorded bit may assert the interrupt line. A recorded bit stays set until the host clears the status. The host clears it with a byte write to any one of the three status addresses, and that single write empties all three banks.

The host reaches the nine byte registers through a byte-wide access port. A transfer starts with `acc_start_i`, which loads the address pointer and moves the port controller from `ST_IDLE` to `ST_OPEN`. Each read or write strobe in `ST_OPEN` then reaches one byte and advances the pointer. This allows a whole bank to be read or written in one burst. `acc_stop_i` moves the controller from `ST_OPEN` back to `ST_IDLE`. A start pulse in `ST_OPEN` reloads the pointer and the controller stays in `ST_OPEN`. There are no other states and no other transitions.

The address map is: status banks A, B and C at 0, 1 and 2; line-mask banks A, B and C at 3, 4 and 5; capture-mask banks A, B and C at 6, 7 and 8. Event `n` sits in bank `n/8`, bit `n%8`.

Top module: `irq_bank_aggregator`

## Requirements
- R1: After reset, every mask byte (addresses 3 to 8) reads 0xFF, every status byte (addresses 0 to 2) reads 0x00, `irq_o` is 0 and `acc_rdata_o` is 0x00.
- R2: A rising edge on `evt_i[n]` sets status bank `n/8` bit `n%8` at the clock edge where it is first seen high, provided that capture-mask bit (address 6 + `n/8`, bit `n%8`) is 0. When that mask bit is 1, the edge is not recorded.
- R3: A set status bit stays set after its event input returns low, until the status is cleared.
- R4: `irq_o` is 1 exactly when some status bit is set while its line-mask bit (address 3 + bank, same bit position) is 0.
- R5: A write strobe of any data value to address 0, 1 or 2 clears all 24 status bits at the same clock edge.
- R6: When an event edge and a status-clear write land on the same clock edge, that event's status bit ends set, and all other bits end cleared.
- R7: Events 12 and 23 are reserved. Their status bits always read 0, and they never assert `irq_o`.
- R8: Each read or write strobe advances the pointer by one. The pointer wraps from address 8 to address 0, and addresses 9 to 15 read 0x00 and ignore writes.
- R9: Three consecutive write strobes after a start load three consecutive registers, so a full mask bank can be loaded in one burst.
- R10: Writing one mask byte changes only that byte. Every other mask byte keeps its value.
- R11: Read and write strobes in `ST_IDLE`, or in the same cycle as a start or a stop, reach no register and do not move the pointer.
- R12: `acc_rdata_o` shows the addressed byte from the cycle after a read strobe. It holds that value until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 24 | Event inputs, one per source |
| acc_start_i | input | 1 | Begins a transfer and loads the pointer from `acc_addr_i` |
| acc_addr_i | input | 4 | Start address of a transfer |
| acc_wr_i | input | 1 | Write strobe for one byte |
| acc_rd_i | input | 1 | Read strobe for one byte |
| acc_stop_i | input | 1 | Ends the transfer |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Interrupt line, active high |

## Verification
The sharpest corner case is an event edge that arrives on the same edge as a clear write. A design that gives the clear priority would drop that event, and the status read that follows would show zero where one bit should be set. Other tests hold an event high across a clear, raise the reserved sources with every mask open, and write a single mask byte before reading the whole bank back. A design that clears only the addressed bank, records reserved sources, or writes across bank boundaries gives wrong read-back values or a wrong interrupt level. Burst tests that start at the last address and at an unmapped address show any mistake in pointer wrap or in address decode. Strobes sent while the port is idle show whether a register was written when it should not have been.

// File: rtl/isa_pkg.sv
package isa_pkg;

    // Access port controller states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } port_state_e;

    // Register group selected by the address pointer
    typedef enum logic [1:0] {
        GRP_STATUS = 2'd0,
        GRP_LMASK  = 2'd1,
        GRP_SMASK  = 2'd2,
        GRP_NONE   = 2'd3
    } reg_group_e;

endpackage

// File: rtl/isa_evt_capture.sv
module isa_evt_capture #(
    parameter int BANKS  = 3,
    parameter int BANK_W = 8,
    parameter logic [BANKS*BANK_W-1:0] RSVD_BITS = 24'h80_1000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [BANKS*BANK_W-1:0] evt_i,
    input  logic [BANKS*BANK_W-1:0] smask_i,
    input  logic                    clr_i,
    output logic [BANKS*BANK_W-1:0] status_o,
    output logic [BANKS*BANK_W-1:0] set_o
);
    localparam int SRC_N = BANKS * BANK_W;

    logic [SRC_N-1:0] prev_q;
    logic [SRC_N-1:0] status_q;
    logic [SRC_N-1:0] set_w;

    // Capture logic for each bank. A set wins over a clear on the same edge.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] rise_w;
        assign rise_w = evt_i[b*BANK_W +: BANK_W] & ~prev_q[b*BANK_W +: BANK_W];
        assign set_w[b*BANK_W +: BANK_W] = rise_w
                                         & ~smask_i[b*BANK_W +: BANK_W]
                                         & ~RSVD_BITS[b*BANK_W +: BANK_W];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[b*BANK_W +: BANK_W]   <= '0;
                status_q[b*BANK_W +: BANK_W] <= '0;
            end else begin
                prev_q[b*BANK_W +: BANK_W] <= evt_i[b*BANK_W +: BANK_W];
                if (clr_i) begin
                    status_q[b*BANK_W +: BANK_W] <= set_w[b*BANK_W +: BANK_W];
                end else begin
                    status_q[b*BANK_W +: BANK_W] <= status_q[b*BANK_W +: BANK_W]
                                                  | set_w[b*BANK_W +: BANK_W];
                end
            end
        end
    end

    assign status_o = status_q;
    assign set_o    = set_w;

endmodule

// File: rtl/isa_irq_merge.sv
module isa_irq_merge #(
    parameter int BANKS  = 3,
    parameter int BANK_W = 8
) (
    input  logic [BANKS*BANK_W-1:0] status_i,
    input  logic [BANKS*BANK_W-1:0] lmask_i,
    output logic                    irq_o
);
    logic [BANKS-1:0] bank_hit;

    for (genvar b = 0; b < BANKS; b++) begin : g_hit
        assign bank_hit[b] = |(status_i[b*BANK_W +: BANK_W] & ~lmask_i[b*BANK_W +: BANK_W]);
    end

    assign irq_o = |bank_hit;

endmodule

// File: rtl/isa_regport.sv
module isa_regport
    import isa_pkg::*;
#(
    parameter int BANKS  = 3,
    parameter int BANK_W = 8,
    parameter int AW     = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [AW-1:0]           addr_i,
    input  logic                    wr_i,
    input  logic                    rd_i,
    input  logic                    stop_i,
    input  logic [BANK_W-1:0]       wdata_i,
    input  logic [BANKS*BANK_W-1:0] status_i,
    output logic [BANKS*BANK_W-1:0] lmask_o,
    output logic [BANKS*BANK_W-1:0] smask_o,
    output logic                    clr_o,
    output logic                    open_o,
    output logic [BANK_W-1:0]       rdata_o
);
    localparam logic [AW-1:0] LIM_STAT  = AW'(BANKS);
    localparam logic [AW-1:0] LIM_LMASK = AW'(2 * BANKS);
    localparam logic [AW-1:0] LIM_SMASK = AW'(3 * BANKS);
    localparam logic [AW-1:0] LAST_REG  = AW'(3 * BANKS - 1);

    port_state_e       state_q, state_d;
    logic [AW-1:0]     ptr_q;
    logic [AW-1:0]     ptr_nxt;
    logic              acc_go, wr_go, rd_go;
    reg_group_e        grp;
    logic [AW-1:0]     bank_idx;
    logic [BANK_W-1:0] rd_mux;
    logic [BANK_W-1:0] rdata_q;

    logic [BANK_W-1:0] lmask_q [BANKS];
    logic [BANK_W-1:0] smask_q [BANKS];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_OPEN;
            ST_OPEN: if (stop_i)  state_d = ST_IDLE;
        endcase
    end

    // A strobe is accepted only in ST_OPEN with no start or stop in the same cycle.
    assign acc_go  = (state_q == ST_OPEN) && !stop_i && !start_i;
    assign wr_go   = acc_go && wr_i;
    assign rd_go   = acc_go && rd_i && !wr_i;
    assign ptr_nxt = (ptr_q == LAST_REG) ? '0 : ptr_q + 1'b1;

    // Address pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) ptr_q <= addr_i;
                ST_OPEN: begin
                    if (stop_i) begin
                        ptr_q <= ptr_q;
                    end else if (start_i) begin
                        ptr_q <= addr_i;
                    end else if (wr_i || rd_i) begin
                        ptr_q <= ptr_nxt;
                    end
                end
            endcase
        end
    end

    // Address decode into a register group and a bank
    always_comb begin
        if (ptr_q < LIM_STAT) begin
            grp      = GRP_STATUS;
            bank_idx = ptr_q;
        end else if (ptr_q < LIM_LMASK) begin
            grp      = GRP_LMASK;
            bank_idx = ptr_q - LIM_STAT;
        end else if (ptr_q < LIM_SMASK) begin
            grp      = GRP_SMASK;
            bank_idx = ptr_q - LIM_LMASK;
        end else begin
            grp      = GRP_NONE;
            bank_idx = '0;
        end
    end

    // Mask byte registers, one per bank and per group
    for (genvar b = 0; b < BANKS; b++) begin : g_mask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lmask_q[b] <= '1;
                smask_q[b] <= '1;
            end else if (wr_go && (bank_idx == AW'(b))) begin
                if (grp == GRP_LMASK) lmask_q[b] <= wdata_i;
                if (grp == GRP_SMASK) smask_q[b] <= wdata_i;
            end
        end
        assign lmask_o[b*BANK_W +: BANK_W] = lmask_q[b];
        assign smask_o[b*BANK_W +: BANK_W] = smask_q[b];
    end

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (bank_idx == AW'(b)) begin
                unique case (grp)
                    GRP_STATUS: rd_mux = status_i[b*BANK_W +: BANK_W];
                    GRP_LMASK:  rd_mux = lmask_q[b];
                    GRP_SMASK:  rd_mux = smask_q[b];
                    GRP_NONE:   rd_mux = '0;
                endcase
            end
        end
    end

    // Output process: registered read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_go) begin
            rdata_q <= rd_mux;
        end
    end

    assign rdata_o = rdata_q;
    assign clr_o   = wr_go && (grp == GRP_STATUS);
    assign open_o  = (state_q == ST_OPEN);

endmodule

// File: rtl/irq_bank_aggregator.sv
module irq_bank_aggregator #(
    parameter int BANKS  = 3,
    parameter int BANK_W = 8,
    parameter logic [BANKS*BANK_W-1:0] RSVD_BITS = 24'h80_1000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [BANKS*BANK_W-1:0] evt_i,
    input  logic                    acc_start_i,
    input  logic [$clog2(3*BANKS)-1:0] acc_addr_i,
    input  logic                    acc_wr_i,
    input  logic                    acc_rd_i,
    input  logic                    acc_stop_i,
    input  logic [BANK_W-1:0]       acc_wdata_i,
    output logic [BANK_W-1:0]       acc_rdata_o,
    output logic                    irq_o
);
    localparam int SRC_N = BANKS * BANK_W;
    localparam int AW    = $clog2(3 * BANKS);

    logic [SRC_N-1:0] status_w;
    logic [SRC_N-1:0] set_w;
    logic [SRC_N-1:0] lmask_w;
    logic [SRC_N-1:0] smask_w;
    logic             clr_w;
    logic             open_w;

    isa_regport #(.BANKS(BANKS), .BANK_W(BANK_W), .AW(AW)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (acc_start_i),
        .addr_i   (acc_addr_i),
        .wr_i     (acc_wr_i),
        .rd_i     (acc_rd_i),
        .stop_i   (acc_stop_i),
        .wdata_i  (acc_wdata_i),
        .status_i (status_w),
        .lmask_o  (lmask_w),
        .smask_o  (smask_w),
        .clr_o    (clr_w),
        .open_o   (open_w),
        .rdata_o  (acc_rdata_o)
    );

    isa_evt_capture #(.BANKS(BANKS), .BANK_W(BANK_W), .RSVD_BITS(RSVD_BITS)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .smask_i  (smask_w),
        .clr_i    (clr_w),
        .status_o (status_w),
        .set_o    (set_w)
    );

    isa_irq_merge #(.BANKS(BANKS), .BANK_W(BANK_W)) u_merge (
        .status_i (status_w),
        .lmask_i  (lmask_w),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/isa_chk.sv
module isa_chk #(
    parameter int SRC_N = 24,
    parameter logic [SRC_N-1:0] RSVD_BITS = 24'h80_1000
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SRC_N-1:0] status,
    input logic [SRC_N-1:0] set_vec,
    input logic [SRC_N-1:0] lmask,
    input logic [SRC_N-1:0] smask,
    input logic             clr,
    input logic             port_open,
    input logic             wr_in,
    input logic             irq
);
    AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((status & $past(status)) == $past(status))); // R3

    AST_MASKED_NOT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & $past(smask)) == '0)); // R2

    AST_CLEAR_KEEPS_ONLY_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (status == $past(set_vec))); // R5

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & RSVD_BITS) == '0)); // R7

    AST_ALL_LINES_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (&lmask) |-> !irq); // R4

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_open && wr_in) |=> ($stable(lmask) && $stable(smask))); // R11
endmodule

bind irq_bank_aggregator isa_chk #(.SRC_N(BANKS*BANK_W), .RSVD_BITS(RSVD_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .status    (status_w),
    .set_vec   (set_w),
    .lmask     (lmask_w),
    .smask     (smask_w),
    .clr       (clr_w),
    .port_open (open_w),
    .wr_in     (acc_wr_i),
    .irq       (irq_o)
);

// File: tb/test_irq_bank_aggregator.sv
module test_irq_bank_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] evt = '0;
    logic        start = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic        stop = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_bank_aggregator i_irq_bank_aggregator (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .acc_start_i (start),
        .acc_addr_i  (addr),
        .acc_wr_i    (wr),
        .acc_rd_i    (rd),
        .acc_stop_i  (stop),
        .acc_wdata_i (wdata),
        .acc_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic open_at(input logic [3:0] a);
        start = 1'b1; addr = a;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic close_port();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] d);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
        open_at(a); wr_byte(d); close_port();
    endtask

    task automatic read_expect(input logic [3:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        open_at(a); rd_byte(v); close_port();
        chk(req, v, exp);
    endtask

    task automatic pulse_evt(input int n);
        evt[n] = 1'b1;
        @(negedge clk);
        evt[n] = 1'b0;
        @(negedge clk);
    endtask

    // R1, R8: reset values over one burst of all nine registers
    task automatic t_reset();
        logic [7:0] v;
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 rdata", rdata, 8'h00);
        open_at(4'd0);
        for (int i = 0; i < 9; i++) begin
            rd_byte(v);
            chk(i < 3 ? "R1 R8 status" : "R1 R8 mask", v, i < 3 ? 8'h00 : 8'hFF);
        end
        close_port();
    endtask

    // R2, R3: capture gated by the capture mask, sticky after input falls
    task automatic t_capture();
        write_reg(4'd6, 8'h00);
        pulse_evt(3);
        pulse_evt(9);
        read_expect(4'd0, 8'h08, "R2 R3 bank A sticky");
        read_expect(4'd1, 8'h00, "R2 masked bank B");
        chk("R4 line masked", {7'd0, irq}, 8'h00);
    endtask

    // R4: line mask gates the interrupt
    task automatic t_irq();
        write_reg(4'd3, 8'hF7);
        chk("R4 unmasked irq", {7'd0, irq}, 8'h01);
        write_reg(4'd3, 8'hFF);
        chk("R4 remasked irq", {7'd0, irq}, 8'h00);
        write_reg(4'd3, 8'hF7);
        chk("R4 irq again", {7'd0, irq}, 8'h01);
    endtask

    // R5: one write to status B clears every bank
    task automatic t_clear();
        write_reg(4'd1, 8'h5A);
        chk("R5 irq after clear", {7'd0, irq}, 8'h00);
        read_expect(4'd0, 8'h00, "R5 bank A cleared");
    endtask

    // R9, R6: burst mask load, then edge coinciding with clear
    task automatic t_coincident();
        logic [7:0] v;
        open_at(4'd6);
        wr_byte(8'h00); wr_byte(8'h00); wr_byte(8'h00);
        close_port();
        open_at(4'd6);
        for (int i = 0; i < 3; i++) begin
            rd_byte(v);
            chk("R9 capture mask burst", v, 8'h00);
        end
        close_port();
        pulse_evt(5);
        open_at(4'd2);
        wr = 1'b1; wdata = 8'hFF; evt[17] = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        close_port();
        evt[17] = 1'b0;
        open_at(4'd0);
        rd_byte(v); chk("R6 bank A cleared", v, 8'h00);
        rd_byte(v); chk("R6 bank B cleared", v, 8'h00);
        rd_byte(v); chk("R6 bank C kept edge", v, 8'h02);
        close_port();
        write_reg(4'd0, 8'h00);
    endtask

    // R7: reserved sources never record and never interrupt
    task automatic t_reserved();
        open_at(4'd3);
        wr_byte(8'h00); wr_byte(8'h00); wr_byte(8'h00);
        close_port();
        pulse_evt(12);
        pulse_evt(23);
        chk("R7 irq", {7'd0, irq}, 8'h00);
        read_expect(4'd1, 8'h00, "R7 bank B");
        read_expect(4'd2, 8'h00, "R7 bank C");
        pulse_evt(22);
        chk("R4 open line irq", {7'd0, irq}, 8'h01);
        read_expect(4'd2, 8'h40, "R2 bank C bit 6");
    endtask

    // R10: single mask byte write touches nothing else
    task automatic t_rmw();
        logic [7:0] v;
        write_reg(4'd3, 8'h11);
        write_reg(4'd4, 8'h3C);
        open_at(4'd3);
        rd_byte(v); chk("R10 line A", v, 8'h11);
        rd_byte(v); chk("R10 line B", v, 8'h3C);
        rd_byte(v); chk("R10 line C", v, 8'h00);
        rd_byte(v); chk("R10 capture A", v, 8'h00);
        close_port();
    endtask

    // R8: wrap from the last address, unmapped reads, ignored writes
    task automatic t_wrap();
        logic [7:0] v;
        write_reg(4'd8, 8'hA5);
        open_at(4'd8);
        rd_byte(v); chk("R8 last reg", v, 8'hA5);
        rd_byte(v); chk("R8 wrap to status A", v, 8'h00);
        rd_byte(v); chk("R8 status B", v, 8'h00);
        rd_byte(v); chk("R8 status C", v, 8'h40);
        close_port();
        open_at(4'd12);
        wr_byte(8'h77);
        rd_byte(v); chk("R8 unmapped reads zero", v, 8'h00);
        close_port();
        read_expect(4'd2, 8'h40, "R8 unmapped write no clear");
    endtask

    // R11, R12: idle strobes ignored, read data holds
    task automatic t_idle();
        logic [7:0] v;
        read_expect(4'd4, 8'h3C, "R12 read line B");
        wr = 1'b1; wdata = 8'h00; rd = 1'b1;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        @(negedge clk);
        chk("R12 rdata held", rdata, 8'h3C);
        chk("R11 status kept, irq", {7'd0, irq}, 8'h01);
        open_at(4'd4);
        stop = 1'b1; wr = 1'b1; wdata = 8'h99;
        @(negedge clk);
        stop = 1'b0; wr = 1'b0;
        open_at(4'd4);
        rd_byte(v); chk("R11 stop-cycle write ignored", v, 8'h3C);
        close_port();
        read_expect(4'd2, 8'h40, "R11 idle write no clear");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture();
        t_irq();
        t_clear();
        t_coincident();
        t_reserved();
        t_rmw();
        t_wrap();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule